// File: doc/BRIEF.md
# Synchronous DRAM Bring-Up Sequencer

This block sits on the controller side of a two-bank synchronous DRAM. It drives the memory from power-on to a usable state. From reset it keeps the clock-enable and data-mask pins high and places only no-operation commands on the bus. It waits out a power-on pause whose cycle count is derived from a clock-frequency parameter. After the pause it closes every bank with a single precharge-all. It then runs a programmable number of auto-refresh commands, with a minimum of two. Last, it loads the mode register with burst length, burst type and CAS latency.

Each command is followed by a parameterized number of idle cycles that cover the precharge, refresh and mode-load recovery times. After the last of these gaps, `init_done` rises and stays high until the next reset. The memory controller must not issue commands of its own before `init_done` is high. Read/write scheduling and periodic refresh belong to other blocks.

Top module: `dram_init_seq`

## Requirements
- R1: While `rst_n` is low, `cke` and every `dqm` bit are 1, `init_done` is 0, `addr` is 0, and the command pins {cs_n,ras_n,cas_n,we_n} show the no-operation code 4'b0111.
- R2: The pause length in cycles is ceil(PAUSE_NS × CLK_KHZ / 1e6). The precharge appears after exactly PAUSE_CYC+2 rising edges following the release of `rst_n`: two edges for reset release, then PAUSE_CYC edges of the pause. Before that point, only the no-operation code is driven.
- R3: The first command after the pause is a precharge, code 4'b0010. During that cycle, bit PALL_BIT of `addr` is 1 and all other address bits are 0, so the precharge covers all banks.
- R4: After the precharge, exactly N_REF auto-refresh commands (code 4'b0001) follow, then one mode-register load (code 4'b0000). The sequence issues no other command.
- R5: The command-to-command spacing is RP_CYC cycles from the precharge to the first refresh, RC_CYC cycles between refreshes and from the last refresh to the mode load, and MRD_CYC cycles from the mode load to `init_done`. Every command lasts one cycle and is followed by the no-operation code.
- R6: During the mode load, `addr[2:0]` = BL_CODE, `addr[3]` = BURST_ILV, `addr[6:4]` = CAS_LAT, and the higher address bits are 0.
- R7: `init_done` rises MRD_CYC cycles after the mode-load cycle and stays high until reset. While it is high, only the no-operation code is driven.
- R8: `cke` and `dqm` stay high throughout the whole sequence and after it.
- R9: Pulling `rst_n` low at any time returns the outputs to the R1 state at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | DQM_W | Data mask lines to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (precharge-all flag, mode word) |
| init_done | output | 1 | High once bring-up has finished |

## Verification
The sequence runs under two parameter sets. The default set has a 100 MHz clock, a 200 µs pause and two refreshes. The second set uses an uneven clock, so the pause product is 99.999 cycles and the ceiling must give 100. That set also has three refreshes, different gap lengths and a different mode word. These runs separate a truncated pause from a rounded-up one and a fixed refresh count from the parameterized one. They also expose swapped gap lengths through the exact edge index of each command, and misplaced mode fields through the mode word. A reset applied after completion shows whether the ready flag and pins return to their reset state without a clock edge.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRECH,
    ST_WAIT_RP,
    ST_REFR,
    ST_WAIT_RC,
    ST_MODE,
    ST_WAIT_MRD,
    ST_READY
  } init_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dram_cmd_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam dram_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam dram_cmd_t CMD_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/dram_init_rst_sync.sv
module dram_init_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
  parameter int unsigned      CNT_W    = 16,
  parameter logic [CNT_W-1:0] INIT_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= INIT_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dram_init_fsm.sv
module dram_init_fsm
  import dram_init_pkg::*;
#(
  parameter int unsigned N_REF   = 2,
  parameter int unsigned RP_CYC  = 3,
  parameter int unsigned RC_CYC  = 7,
  parameter int unsigned MRD_CYC = 2,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned REF_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_zero,
  output init_state_e      state_q,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] RP_LD    = CNT_W'(RP_CYC - 2);
  localparam logic [CNT_W-1:0] RC_LD    = CNT_W'(RC_CYC - 2);
  localparam logic [CNT_W-1:0] MRD_LD   = CNT_W'(MRD_CYC - 2);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(N_REF);

  init_state_e      state_d;
  logic [REF_W-1:0] ref_q;
  logic [REF_W-1:0] ref_d;
  logic             ref_en;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_en   = 1'b0;
    ref_d    = ref_q + 1'b1;
    case (state_q)
      ST_PAUSE:    if (tmr_zero) state_d = ST_PRECH;
      ST_PRECH: begin
        tmr_load = 1'b1;
        tmr_val  = RP_LD;
        state_d  = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (tmr_zero) state_d = ST_REFR;
      ST_REFR: begin
        tmr_load = 1'b1;
        tmr_val  = RC_LD;
        ref_en   = 1'b1;
        state_d  = ST_WAIT_RC;
      end
      ST_WAIT_RC: begin
        if (tmr_zero) begin
          state_d = (ref_q == REF_LAST) ? ST_MODE : ST_REFR;
        end
      end
      ST_MODE: begin
        tmr_load = 1'b1;
        tmr_val  = MRD_LD;
        state_d  = ST_WAIT_MRD;
      end
      ST_WAIT_MRD: if (tmr_zero) state_d = ST_READY;
      ST_READY:    state_d = ST_READY;
      default:     state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PAUSE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
    end else if (ref_en) begin
      ref_q <= ref_d;
    end
  end

endmodule

// File: rtl/dram_init_drv.sv
module dram_init_drv
  import dram_init_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned PALL_BIT  = 10,
  parameter logic [2:0]  BL_CODE   = 3'd3,
  parameter logic        BURST_ILV = 1'b0,
  parameter logic [2:0]  CAS_LAT   = 3'd3
) (
  input  init_state_e       state,
  output dram_cmd_t         cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam logic [ADDR_W-1:0] PALL_WORD = ADDR_W'(1) << PALL_BIT;
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'({CAS_LAT, BURST_ILV, BL_CODE});

  always_comb begin
    cmd   = CMD_NOP;
    addr  = '0;
    ready = 1'b0;
    case (state)
      ST_PRECH: begin
        cmd  = CMD_PRE;
        addr = PALL_WORD;
      end
      ST_REFR:  cmd = CMD_REF;
      ST_MODE: begin
        cmd  = CMD_MODE;
        addr = MODE_WORD;
      end
      ST_READY: ready = 1'b1;
      default:  cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 100000,
  parameter int unsigned PAUSE_NS  = 200000,
  parameter int unsigned RP_CYC    = 3,
  parameter int unsigned RC_CYC    = 7,
  parameter int unsigned MRD_CYC   = 2,
  parameter int unsigned N_REF     = 2,
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned PALL_BIT  = 10,
  parameter int unsigned DQM_W     = 4,
  parameter logic [2:0]  BL_CODE   = 3'd3,
  parameter logic        BURST_ILV = 1'b0,
  parameter logic [2:0]  CAS_LAT   = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam longint unsigned PAUSE_CYC_L =
    (64'(PAUSE_NS) * 64'(CLK_KHZ) + 64'd999999) / 64'd1000000;
  localparam int unsigned PAUSE_CYC = 32'(PAUSE_CYC_L);
  localparam int unsigned MAX_A  = (RP_CYC > RC_CYC) ? RP_CYC : RC_CYC;
  localparam int unsigned MAX_B  = (MAX_A > MRD_CYC) ? MAX_A : MRD_CYC;
  localparam int unsigned MAX_LD = (MAX_B > PAUSE_CYC) ? MAX_B : PAUSE_CYC;
  localparam int unsigned CNT_W  = $clog2(MAX_LD + 1);
  localparam int unsigned REF_W  = $clog2(N_REF + 1);
  localparam logic [CNT_W-1:0] PAUSE_LD = CNT_W'(PAUSE_CYC - 1);

  logic             rst_n_int;
  logic             tmr_zero;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  init_state_e      state;
  dram_cmd_t        cmd;

  dram_init_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dram_init_timer #(
    .CNT_W    (CNT_W),
    .INIT_VAL (PAUSE_LD)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  dram_init_fsm #(
    .N_REF   (N_REF),
    .RP_CYC  (RP_CYC),
    .RC_CYC  (RC_CYC),
    .MRD_CYC (MRD_CYC),
    .CNT_W   (CNT_W),
    .REF_W   (REF_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .tmr_zero (tmr_zero),
    .state_q  (state),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  dram_init_drv #(
    .ADDR_W    (ADDR_W),
    .PALL_BIT  (PALL_BIT),
    .BL_CODE   (BL_CODE),
    .BURST_ILV (BURST_ILV),
    .CAS_LAT   (CAS_LAT)
  ) u_drv (
    .state (state),
    .cmd   (cmd),
    .addr  (addr),
    .ready (init_done)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
  assign cke   = 1'b1;
  assign dqm   = '1;

endmodule

// File: rtl/dram_init_chk.sv
module dram_init_chk #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned PALL_BIT = 10,
  parameter int unsigned N_REF    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  logic [3:0] cmd;
  logic [7:0] refs_q;
  logic       mode_seen_q;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refs_q      <= '0;
      mode_seen_q <= 1'b0;
    end else begin
      if (cmd == 4'b0001 && refs_q != 8'hff) refs_q <= refs_q + 1'b1;
      if (cmd == 4'b0000) mode_seen_q <= 1'b1;
    end
  end

  p_single_cycle_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 4'b0111) |=> (cmd == 4'b0111));

  p_pre_allbanks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> addr[PALL_BIT]);

  p_mode_after_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> (refs_q == 8'(N_REF)));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(init_done));

  p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == 4'b0111));

  p_done_after_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> mode_seen_q);

endmodule

bind dram_init_seq dram_init_chk #(
  .ADDR_W   (ADDR_W),
  .PALL_BIT (PALL_BIT),
  .N_REF    (N_REF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/sim_dram_init_seq.sv
module sim_dram_init_seq;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic        cke0, cs0, ras0, cas0, we0, done0;
  logic [3:0]  dqm0;
  logic [10:0] addr0;
  logic        cke1, cs1, ras1, cas1, we1, done1;
  logic [3:0]  dqm1;
  logic [10:0] addr1;

  dram_init_seq u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke0), .dqm(dqm0), .cs_n(cs0), .ras_n(ras0),
    .cas_n(cas0), .we_n(we0), .addr(addr0), .init_done(done0)
  );

  dram_init_seq #(
    .CLK_KHZ(33333), .PAUSE_NS(3000), .RP_CYC(2), .RC_CYC(4), .MRD_CYC(3),
    .N_REF(3), .BL_CODE(3'b010), .BURST_ILV(1'b1), .CAS_LAT(3'b010)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .cke(cke1), .dqm(dqm1), .cs_n(cs1), .ras_n(ras1),
    .cas_n(cas1), .we_n(we1), .addr(addr1), .init_done(done1)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  bit   mon_en = 1'b0;
  int   cyc = 0;
  int   e0_cyc [8];
  logic [3:0]  e0_cmd [8];
  logic [10:0] e0_adr [8];
  int   n0 = 0;
  int   e1_cyc [8];
  logic [3:0]  e1_cmd [8];
  logic [10:0] e1_adr [8];
  int   n1 = 0;
  int   done0_cyc = 0, done1_cyc = 0;
  bit   fell0 = 1'b0, fell1 = 1'b0, low_pin = 1'b0;

  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      cyc = cyc + 1;
      if ({cs0, ras0, cas0, we0} != 4'b0111) begin
        if (n0 < 8) begin
          e0_cyc[n0] = cyc; e0_cmd[n0] = {cs0, ras0, cas0, we0}; e0_adr[n0] = addr0;
        end
        n0 = n0 + 1;
      end
      if ({cs1, ras1, cas1, we1} != 4'b0111) begin
        if (n1 < 8) begin
          e1_cyc[n1] = cyc; e1_cmd[n1] = {cs1, ras1, cas1, we1}; e1_adr[n1] = addr1;
        end
        n1 = n1 + 1;
      end
      if (done0 && done0_cyc == 0) done0_cyc = cyc;
      if (!done0 && done0_cyc != 0) fell0 = 1'b1;
      if (done1 && done1_cyc == 0) done1_cyc = cyc;
      if (!done1 && done1_cyc != 0) fell1 = 1'b1;
      if (!cke0 || dqm0 != 4'hf || !cke1 || dqm1 != 4'hf) low_pin = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    chk("R1 cke", 32'(cke0), 32'd1);
    chk("R1 dqm", 32'(dqm0), 32'hf);
    chk("R1 cmd", 32'({cs0, ras0, cas0, we0}), 32'h7);
    chk("R1 addr", 32'(addr0), 32'h0);
    chk("R1 done", 32'(done0), 32'd0);
  endtask

  task automatic t_release_and_run();
    @(negedge clk);
    rst_n  = 1'b1;
    cyc    = 0;
    mon_en = 1'b1;
    repeat (20100) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_pause();
    chk("R2 precharge edge index", 32'(e0_cyc[0]), 32'd20002);
    chk("R2 first command is precharge", 32'(e0_cmd[0]), 32'h2);
  endtask

  task automatic t_precharge();
    chk("R3 precharge-all address", 32'(e0_adr[0]), 32'h400);
  endtask

  task automatic t_refresh();
    chk("R4 command count", 32'(n0), 32'd4);
    chk("R4 refresh 1", 32'(e0_cmd[1]), 32'h1);
    chk("R4 refresh 2", 32'(e0_cmd[2]), 32'h1);
    chk("R4 mode load last", 32'(e0_cmd[3]), 32'h0);
  endtask

  task automatic t_gaps();
    chk("R5 precharge to refresh", 32'(e0_cyc[1] - e0_cyc[0]), 32'd3);
    chk("R5 refresh to refresh", 32'(e0_cyc[2] - e0_cyc[1]), 32'd7);
    chk("R5 refresh to mode", 32'(e0_cyc[3] - e0_cyc[2]), 32'd7);
  endtask

  task automatic t_mode();
    chk("R6 mode word", 32'(e0_adr[3]), 32'h033);
  endtask

  task automatic t_done();
    chk("R7 done delay", 32'(done0_cyc - e0_cyc[3]), 32'd2);
    chk("R7 done held", 32'(fell0), 32'd0);
    chk("R7 done now", 32'(done0), 32'd1);
    chk("R7 quiet after done", 32'({cs0, ras0, cas0, we0}), 32'h7);
  endtask

  task automatic t_pins();
    chk("R8 cke and dqm high", 32'(low_pin), 32'd0);
  endtask

  task automatic t_second_config();
    chk("R2 rounded pause", 32'(e1_cyc[0]), 32'd102);
    chk("R4 refresh count three", 32'(n1), 32'd5);
    chk("R4 third refresh", 32'(e1_cmd[3]), 32'h1);
    chk("R4 mode after three", 32'(e1_cmd[4]), 32'h0);
    chk("R5 rp gap", 32'(e1_cyc[1] - e1_cyc[0]), 32'd2);
    chk("R5 rc gap", 32'(e1_cyc[3] - e1_cyc[2]), 32'd4);
    chk("R5 rc to mode", 32'(e1_cyc[4] - e1_cyc[3]), 32'd4);
    chk("R6 mode word second set", 32'(e1_adr[4]), 32'h02a);
    chk("R7 done delay second set", 32'(done1_cyc - e1_cyc[4]), 32'd3);
    chk("R7 done held second set", 32'(fell1), 32'd0);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    #1;
    chk("R9 done cleared", 32'(done0), 32'd0);
    chk("R9 done cleared second set", 32'(done1), 32'd0);
    chk("R9 cmd nop", 32'({cs0, ras0, cas0, we0}), 32'h7);
    chk("R9 cke", 32'(cke0), 32'd1);
    chk("R9 addr", 32'(addr0), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_release_and_run();
    t_pause();
    t_precharge();
    t_refresh();
    t_gaps();
    t_mode();
    t_done();
    t_pins();
    t_second_config();
    t_reset_again();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule